// File: doc/BRIEF.md
# LCD Power and Mode Command Sequencer

This block sends command scripts to a graphic LCD controller over a serial link that only writes. The link has four lines: a serial clock, a serial data line, an active-low chip select and a command/data select. A requester asks for one of four operations: power-up, sleep entry, sleep exit, or a contrast change. The block then selects the controller, shifts out the bytes for that operation, inserts the long pauses the script needs, and releases the controller. The pauses are measured with a millisecond tick counter. Every edge of chip select or of command/data select is followed by a settle time, counted in system clocks, before anything else happens on the link.

Requests use a valid/ready handshake. A request is accepted only in a cycle where `req_valid` and `req_ready` are both high. The block stores nothing that is offered while `req_ready` is low. A requester that wants its request honoured must hold it until ready returns. A request that is dropped instead has no effect. `busy` is high from acceptance until the script has finished, and `done` pulses for one cycle when it finishes. Neither signal has any back-pressure of its own.

After reset, all four link lines are low. The block then raises chip select and waits one settle time before it accepts its first request.

Top module: `lcd_cmd_seq`

## Requirements
- R1: Each byte is shifted out most significant bit first. For each bit, `lcd_sck` is low while `lcd_sdo` takes the new bit, then `lcd_sck` rises for `BIT_HALF` clocks and falls again. `lcd_sdo` never changes in the cycle where `lcd_sck` rises, and `lcd_sck` stays low whenever the controller is deselected.
- R2: `lcd_dc` is low (command) whenever `lcd_csn` is low. `lcd_csn` is low only while a script is running.
- R3: Power-up (`req_op` = 2'b00) sends, in this order: A2, A0, C8, 40, 2C, 2E, 2F, 10, A6, 81, 1E, AF (hex).
- R4: After the power-up bytes, the block waits 100 ms, sends A5, waits 200 ms, sends A4, and then releases chip select. One ms is `TICKS_PER_MS` clocks.
- R5: Sleep entry (`req_op` = 2'b01) sends AC, 00, AE, A5 and then releases chip select.
- R6: Sleep exit (`req_op` = 2'b10) sends A4, AF, waits 50 ms and then releases chip select.
- R7: A contrast request (`req_op` = 2'b11) sends 81 and then `req_level` shifted right by two, with the top two bits zero. This holds for all 256 level values.
- R8: During reset, `lcd_sck`, `lcd_sdo`, `lcd_csn` and `lcd_dc` are all low. After reset, `lcd_csn` goes high before `req_ready` first goes high, and no serial clock pulse comes before that point.
- R9: After chip select falls, at least `SETTLE_CLKS` clocks pass before the first clock rise. After chip select rises, exactly `SETTLE_CLKS` clocks pass before `done`. Chip select changes only while `lcd_sck` is low.
- R10: A request made while `busy` is high is ignored: `req_ready` is low, and the bytes on the link are those of the script already running.
- R11: `busy` rises in the cycle after acceptance and stays high while chip select is low. `done` is a one-cycle pulse, and `busy` falls in the same cycle as `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | 00 power-up, 01 sleep entry, 10 sleep exit, 11 contrast |
| req_level | input | 8 | Contrast level, used by op 11 |
| busy | output | 1 | Script in progress |
| done | output | 1 | One-cycle pulse when a script ends |
| lcd_sck | output | 1 | Serial clock |
| lcd_sdo | output | 1 | Serial data, most significant bit first |
| lcd_csn | output | 1 | Controller select, active low |
| lcd_dc | output | 1 | Command/data select, low for command |

## Verification
The bench decodes the serial lines into bytes. It sweeps all 256 contrast levels, so a scaling that drops the shift, keeps the low bits or leaves stray top bits gives wrong bytes. It times the 100, 200 and 50 ms pauses in clocks. A wrong tick limit or a pause placed at the wrong step moves them outside their windows. It measures the settle gaps and the moment chip select first rises after reset, which catches a lost settle count and a select that goes low before its first script. It also offers a request in the middle of a script; a block that takes that request would change the byte log.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [1:0] {
    OP_POWER_UP  = 2'b00,
    OP_SLEEP_IN  = 2'b01,
    OP_SLEEP_OUT = 2'b10,
    OP_CONTRAST  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    STP_SEL,
    STP_BYTE,
    STP_LEVEL,
    STP_WAIT,
    STP_REL
  } step_kind_e;

  typedef struct packed {
    step_kind_e kind;
    logic [7:0] arg;
  } step_t;

  localparam int unsigned IDX_W     = 5;
  localparam logic [7:0] WARM_MS    = 8'd100;
  localparam logic [7:0] FLASH_MS   = 8'd200;
  localparam logic [7:0] WAKE_MS    = 8'd50;

  function automatic step_t mk(step_kind_e k, logic [7:0] a);
    step_t s;
    s.kind = k;
    s.arg  = a;
    return s;
  endfunction

  // Script table: each op is a list of steps starting at index 0.
  function automatic step_t script_step(op_e op, logic [IDX_W-1:0] idx);
    step_t s;
    s = mk(STP_REL, 8'h00);
    unique case (op)
      OP_POWER_UP: begin
        case (idx)
          5'd0:  s = mk(STP_SEL,  8'h00);
          5'd1:  s = mk(STP_BYTE, 8'hA2);
          5'd2:  s = mk(STP_BYTE, 8'hA0);
          5'd3:  s = mk(STP_BYTE, 8'hC8);
          5'd4:  s = mk(STP_BYTE, 8'h40);
          5'd5:  s = mk(STP_BYTE, 8'h2C);
          5'd6:  s = mk(STP_BYTE, 8'h2E);
          5'd7:  s = mk(STP_BYTE, 8'h2F);
          5'd8:  s = mk(STP_BYTE, 8'h10);
          5'd9:  s = mk(STP_BYTE, 8'hA6);
          5'd10: s = mk(STP_BYTE, 8'h81);
          5'd11: s = mk(STP_BYTE, 8'h1E);
          5'd12: s = mk(STP_BYTE, 8'hAF);
          5'd13: s = mk(STP_WAIT, WARM_MS);
          5'd14: s = mk(STP_BYTE, 8'hA5);
          5'd15: s = mk(STP_WAIT, FLASH_MS);
          5'd16: s = mk(STP_BYTE, 8'hA4);
          default: s = mk(STP_REL, 8'h00);
        endcase
      end
      OP_SLEEP_IN: begin
        case (idx)
          5'd0: s = mk(STP_SEL,  8'h00);
          5'd1: s = mk(STP_BYTE, 8'hAC);
          5'd2: s = mk(STP_BYTE, 8'h00);
          5'd3: s = mk(STP_BYTE, 8'hAE);
          5'd4: s = mk(STP_BYTE, 8'hA5);
          default: s = mk(STP_REL, 8'h00);
        endcase
      end
      OP_SLEEP_OUT: begin
        case (idx)
          5'd0: s = mk(STP_SEL,  8'h00);
          5'd1: s = mk(STP_BYTE, 8'hA4);
          5'd2: s = mk(STP_BYTE, 8'hAF);
          5'd3: s = mk(STP_WAIT, WAKE_MS);
          default: s = mk(STP_REL, 8'h00);
        endcase
      end
      OP_CONTRAST: begin
        case (idx)
          5'd0: s = mk(STP_SEL,   8'h00);
          5'd1: s = mk(STP_BYTE,  8'h81);
          5'd2: s = mk(STP_LEVEL, 8'h00);
          default: s = mk(STP_REL, 8'h00);
        endcase
      end
      default: s = mk(STP_REL, 8'h00);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/lcd_bit_shifter.sv
module lcd_bit_shifter #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned BIT_HALF = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [BYTE_W-1:0] byte_in,
  output logic              sck,
  output logic              sdo,
  output logic              done
);

  localparam int unsigned CNT_W = $clog2(BIT_HALF + 1);
  localparam int unsigned BIT_W = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {SH_IDLE, SH_LOW, SH_HIGH} sh_state_e;

  sh_state_e         st_q;
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SH_IDLE;
      sh_q   <= '0;
      cnt_q  <= '0;
      bits_q <= '0;
      sck    <= 1'b0;
      sdo    <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        sh_q   <= byte_in;
        sdo    <= byte_in[BYTE_W-1];
        sck    <= 1'b0;
        bits_q <= BIT_W'(BYTE_W);
        cnt_q  <= CNT_W'(BIT_HALF - 1);
        st_q   <= SH_LOW;
      end else begin
        unique case (st_q)
          SH_LOW: begin
            if (cnt_q == '0) begin
              sck   <= 1'b1;
              cnt_q <= CNT_W'(BIT_HALF - 1);
              st_q  <= SH_HIGH;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          SH_HIGH: begin
            if (cnt_q == '0) begin
              sck <= 1'b0;
              if (bits_q == BIT_W'(1)) begin
                done <= 1'b1;
                st_q <= SH_IDLE;
              end else begin
                bits_q <= bits_q - 1'b1;
                sh_q   <= sh_q << 1;
                sdo    <= sh_q[BYTE_W-2];
                cnt_q  <= CNT_W'(BIT_HALF - 1);
                st_q   <= SH_LOW;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_SDO_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(sdo)) else $error("sdo moved at sck rise"); // R1

  AST_NO_RESTART_MIDBYTE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (st_q == SH_IDLE)) else $error("byte started while shifting"); // R1

endmodule

// File: rtl/lcd_ms_timer.sv
module lcd_ms_timer #(
  parameter int unsigned TICKS_PER_MS = 125000,
  parameter int unsigned MS_W         = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [MS_W-1:0] ms,
  output logic            done
);

  localparam int unsigned TICK_W = $clog2(TICKS_PER_MS + 1);

  logic              run_q;
  logic [TICK_W-1:0] tick_q;
  logic [MS_W-1:0]   left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      tick_q <= '0;
      left_q <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        if (ms == '0) begin
          done <= 1'b1;
        end else begin
          run_q  <= 1'b1;
          left_q <= ms;
          tick_q <= TICK_W'(TICKS_PER_MS - 1);
        end
      end else if (run_q) begin
        if (tick_q == '0) begin
          if (left_q == MS_W'(1)) begin
            run_q <= 1'b0;
            done  <= 1'b1;
          end else begin
            left_q <= left_q - 1'b1;
            tick_q <= TICK_W'(TICKS_PER_MS - 1);
          end
        end else begin
          tick_q <= tick_q - 1'b1;
        end
      end
    end
  end

  AST_TIMER_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !run_q) else $error("pause restarted while running"); // R4

  AST_TIMER_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !run_q) else $error("timer still running at done"); // R6

endmodule

// File: rtl/lcd_cmd_seq.sv
module lcd_cmd_seq
  import lcd_seq_pkg::*;
#(
  parameter int unsigned TICKS_PER_MS = 125000,
  parameter int unsigned SETTLE_CLKS  = 8,
  parameter int unsigned BIT_HALF     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [1:0] req_op,
  input  logic [7:0] req_level,
  output logic       busy,
  output logic       done,
  output logic       lcd_sck,
  output logic       lcd_sdo,
  output logic       lcd_csn,
  output logic       lcd_dc
);

  localparam int unsigned SET_W = $clog2(SETTLE_CLKS + 1);
  localparam int unsigned MS_W  = 8;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_STEP, ST_SETTLE, ST_SHIFT, ST_WAIT
  } seq_state_e;

  seq_state_e       st_q;
  op_e              op_q;
  logic [7:0]       level_q;
  logic [IDX_W-1:0] idx_q;
  logic [SET_W-1:0] settle_q;
  logic             fin_q;
  logic             notify_q;
  logic             csn_q;
  logic             dc_q;
  logic             done_q;
  logic             shf_start_q;
  logic [7:0]       shf_byte_q;
  logic             tmr_start_q;
  logic [MS_W-1:0]  tmr_ms_q;
  logic             shf_done;
  logic             tmr_done;
  step_t            cur;

  assign cur = script_step(op_q, idx_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_BOOT;
      op_q        <= OP_POWER_UP;
      level_q     <= '0;
      idx_q       <= '0;
      settle_q    <= '0;
      fin_q       <= 1'b0;
      notify_q    <= 1'b0;
      csn_q       <= 1'b0;
      dc_q        <= 1'b0;
      done_q      <= 1'b0;
      shf_start_q <= 1'b0;
      shf_byte_q  <= '0;
      tmr_start_q <= 1'b0;
      tmr_ms_q    <= '0;
    end else begin
      done_q      <= 1'b0;
      shf_start_q <= 1'b0;
      tmr_start_q <= 1'b0;
      unique case (st_q)
        ST_BOOT: begin
          csn_q    <= 1'b1;
          settle_q <= SET_W'(SETTLE_CLKS - 1);
          fin_q    <= 1'b1;
          notify_q <= 1'b0;
          st_q     <= ST_SETTLE;
        end
        ST_IDLE: begin
          if (req_valid) begin
            op_q    <= op_e'(req_op);
            level_q <= req_level;
            idx_q   <= '0;
            st_q    <= ST_STEP;
          end
        end
        ST_STEP: begin
          idx_q <= idx_q + 1'b1;
          unique case (cur.kind)
            STP_SEL: begin
              dc_q     <= 1'b0;
              csn_q    <= 1'b0;
              settle_q <= SET_W'(SETTLE_CLKS - 1);
              fin_q    <= 1'b0;
              st_q     <= ST_SETTLE;
            end
            STP_BYTE: begin
              shf_byte_q  <= cur.arg;
              shf_start_q <= 1'b1;
              st_q        <= ST_SHIFT;
            end
            STP_LEVEL: begin
              shf_byte_q  <= {2'b00, level_q[7:2]};
              shf_start_q <= 1'b1;
              st_q        <= ST_SHIFT;
            end
            STP_WAIT: begin
              tmr_ms_q    <= cur.arg;
              tmr_start_q <= 1'b1;
              st_q        <= ST_WAIT;
            end
            default: begin
              csn_q    <= 1'b1;
              settle_q <= SET_W'(SETTLE_CLKS - 1);
              fin_q    <= 1'b1;
              notify_q <= 1'b1;
              st_q     <= ST_SETTLE;
            end
          endcase
        end
        ST_SETTLE: begin
          if (settle_q == '0) begin
            if (fin_q) begin
              done_q <= notify_q;
              st_q   <= ST_IDLE;
            end else begin
              st_q <= ST_STEP;
            end
          end else begin
            settle_q <= settle_q - 1'b1;
          end
        end
        ST_SHIFT: if (shf_done) st_q <= ST_STEP;
        ST_WAIT:  if (tmr_done) st_q <= ST_STEP;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  lcd_bit_shifter #(.BYTE_W(8), .BIT_HALF(BIT_HALF)) shifter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (shf_start_q),
    .byte_in (shf_byte_q),
    .sck     (lcd_sck),
    .sdo     (lcd_sdo),
    .done    (shf_done)
  );

  lcd_ms_timer #(.TICKS_PER_MS(TICKS_PER_MS), .MS_W(MS_W)) timer_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (tmr_start_q),
    .ms    (tmr_ms_q),
    .done  (tmr_done)
  );

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign lcd_csn   = csn_q;
  assign lcd_dc    = dc_q;

  AST_DC_LOW_WHEN_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_csn |-> !lcd_dc) else $error("data mode while selected"); // R2

  AST_SCK_IDLE_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_csn |-> !lcd_sck) else $error("clock pulse with controller released"); // R1

  AST_CSN_MOVES_SCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lcd_csn) |-> !lcd_sck) else $error("select moved while sck high"); // R9

  AST_BUSY_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_csn |-> busy) else $error("selected but not busy"); // R11

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R11

  AST_REQ_IGNORED_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> (op_q == $past(op_q) && level_q == $past(level_q)))
    else $error("request taken while busy"); // R10

endmodule

// File: tb/lcd_cmd_seq_tb_top.sv
module lcd_cmd_seq_tb_top;

  localparam int unsigned TPM    = 4;
  localparam int unsigned SETTLE = 3;
  localparam int unsigned HALF   = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [7:0] req_level = 8'h00;
  logic       req_ready, busy, done;
  logic       lcd_sck, lcd_sdo, lcd_csn, lcd_dc;

  always #4 clk = ~clk;

  lcd_cmd_seq #(.TICKS_PER_MS(TPM), .SETTLE_CLKS(SETTLE), .BIT_HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_level(req_level), .busy(busy), .done(done),
    .lcd_sck(lcd_sck), .lcd_sdo(lcd_sdo), .lcd_csn(lcd_csn), .lcd_dc(lcd_dc)
  );

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // Serial line monitor, sampled at the falling clock edge.
  logic [7:0] got [0:31];
  int first_rise [0:31];
  int last_rise [0:31];
  int got_n = 0;
  int bitn = 0;
  logic [7:0] sh = 8'h00;
  int csn_fall_cyc = 0, csn_rise_cyc = 0, done_cyc = 0;
  int stray = 0, dc_hi = 0, csn_rises = 0;
  logic prev_sck = 1'b0, prev_csn = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_sck && lcd_sck) begin
        if (lcd_csn) stray = stray + 1;
        else begin
          if (bitn == 0 && got_n < 32) first_rise[got_n] = cyc;
          sh = {sh[6:0], lcd_sdo};
          bitn = bitn + 1;
          if (bitn == 8) begin
            if (got_n < 32) begin
              got[got_n] = sh;
              last_rise[got_n] = cyc;
            end
            got_n = got_n + 1;
            bitn = 0;
          end
        end
      end
      if (prev_csn && !lcd_csn) csn_fall_cyc = cyc;
      if (!prev_csn && lcd_csn) begin
        csn_rise_cyc = cyc;
        csn_rises = csn_rises + 1;
      end
      if (!lcd_csn && lcd_dc) dc_hi = dc_hi + 1;
      if (done) done_cyc = cyc;
    end
    prev_sck = lcd_sck;
    prev_csn = lcd_csn;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    got_n = 0;
    bitn = 0;
    stray = 0;
    dc_hi = 0;
  endtask

  // Issue a request and wait for its done pulse; checks R11 along the way.
  task automatic run_op(input logic [1:0] op, input logic [7:0] lvl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    clear_log();
    req_valid = 1'b1;
    req_op = op;
    req_level = lvl;
    @(negedge clk);
    req_valid = 1'b0;
    check(busy == 1'b1, "R11 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    check(busy == 1'b0, "R11 busy falls with done", busy, 0);
    @(negedge clk);
    check(done == 1'b0, "R11 done one cycle", done, 0);
  endtask

  function automatic logic [7:0] pu_byte(int i);
    case (i)
      0: return 8'hA2;  1: return 8'hA0;  2: return 8'hC8;  3: return 8'h40;
      4: return 8'h2C;  5: return 8'h2E;  6: return 8'h2F;  7: return 8'h10;
      8: return 8'hA6;  9: return 8'h81; 10: return 8'h1E; 11: return 8'hAF;
      12: return 8'hA5; default: return 8'hA4;
    endcase
  endfunction

  function automatic logic [7:0] si_byte(int i);
    case (i)
      0: return 8'hAC; 1: return 8'h00; 2: return 8'hAE; default: return 8'hA5;
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog expired actual=%0d expected=<200000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin : main
    int gap;
    int ok;
    // R8: reset levels
    repeat (3) @(negedge clk);
    check({lcd_sck, lcd_sdo, lcd_csn, lcd_dc} == 4'b0000, "R8 reset lines low",
          {lcd_sck, lcd_sdo, lcd_csn, lcd_dc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    check(lcd_csn == 1'b1, "R8 select raised before ready", lcd_csn, 1);
    check(stray == 0 && got_n == 0, "R8 no clock before ready", got_n + stray, 0);
    check(csn_rises == 1, "R8 one select rise at boot", csn_rises, 1);

    // R3/R4 power-up
    run_op(2'b00, 8'h00);
    check(got_n == 14, "R3 power-up byte count", got_n, 14);
    ok = 1;
    for (int i = 0; i < 14; i++) if (got[i] != pu_byte(i)) ok = 0;
    check(ok == 1, "R3 power-up byte order", got[0], pu_byte(0));
    check(got[12] == 8'hA5 && got[13] == 8'hA4, "R4 trailer bytes", {got[12], got[13]}, 16'hA5A4);
    gap = first_rise[12] - last_rise[11];
    check(gap >= 100*TPM && gap <= 100*TPM + 2*HALF + 10, "R4 100 ms pause", gap, 100*TPM);
    gap = first_rise[13] - last_rise[12];
    check(gap >= 200*TPM && gap <= 200*TPM + 2*HALF + 10, "R4 200 ms pause", gap, 200*TPM);
    check(dc_hi == 0 && stray == 0, "R2 command mode, no stray clock", dc_hi + stray, 0);
    check(first_rise[0] - csn_fall_cyc >= SETTLE, "R9 settle after select",
          first_rise[0] - csn_fall_cyc, SETTLE);
    check(done_cyc - csn_rise_cyc == SETTLE, "R9 settle after release",
          done_cyc - csn_rise_cyc, SETTLE);
    check(csn_rise_cyc - last_rise[13] >= HALF, "R9 release after last clock",
          csn_rise_cyc - last_rise[13], HALF);

    // R5 sleep entry
    run_op(2'b01, 8'h00);
    ok = (got_n == 4);
    for (int i = 0; i < 4; i++) if (got[i] != si_byte(i)) ok = 0;
    check(ok == 1, "R5 sleep entry bytes", got_n, 4);
    check(lcd_csn == 1'b1, "R2 released after sleep entry", lcd_csn, 1);

    // R6 sleep exit
    run_op(2'b10, 8'h00);
    check(got_n == 2 && got[0] == 8'hA4 && got[1] == 8'hAF, "R6 sleep exit bytes",
          {got[0], got[1]}, 16'hA4AF);
    gap = csn_rise_cyc - last_rise[1];
    check(gap >= 50*TPM && gap <= 50*TPM + 2*HALF + 10, "R6 50 ms pause before release",
          gap, 50*TPM);

    // R10 request during a script is ignored
    @(negedge clk);
    clear_log();
    req_valid = 1'b1; req_op = 2'b01; req_level = 8'h00;
    @(negedge clk);
    req_op = 2'b11; req_level = 8'hFF;
    repeat (20) @(negedge clk);
    check(req_ready == 1'b0, "R10 ready low while busy", req_ready, 0);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (60) @(negedge clk);
    ok = (got_n == 4);
    for (int i = 0; i < 4; i++) if (got[i] != si_byte(i)) ok = 0;
    check(ok == 1, "R10 busy request ignored", got_n, 4);

    // R7 contrast sweep over every level
    for (int v = 0; v < 256; v++) begin
      run_op(2'b11, 8'(v));
      check(got_n == 2 && got[0] == 8'h81 && got[1] == 8'(v / 4),
            "R7 contrast bytes", {got[0], got[1]}, {8'h81, 8'(v / 4)});
      if (v == 0 || v == 255)
        check(first_rise[0] - csn_fall_cyc >= SETTLE, "R9 contrast settle",
              first_rise[0] - csn_fall_cyc, SETTLE);
    end
    check(dc_hi == 0 && stray == 0, "R1 no clock outside select", dc_hi + stray, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule